// File: doc/BRIEF.md
# Serial DAC Control Port

This block is the digital front of a pair of 10-bit converters. A host writes it over three wires: a data line, a shift clock that idles low, and a write strobe. Each rising edge of the shift clock moves one data bit into a 12-bit shift register. A rising edge of the strobe then copies the register's payload into one of two parallel holding registers. The one-bit address inside the frame picks the register: one drives the gain-control converter, the other a general-purpose converter.

A frame holds three fields, sent most significant first. The first bit is a don't-care marker. The second is the register address. The last ten bits are the data value. The host may shift more than twelve bits before it strobes. Only the twelve bits shifted most recently count, because the older ones fall off the top of the register. The shift clock and the strobe are sampled by a faster system clock, through synchronizer chains with edge detection, so the whole block runs in one clock domain. Each commit raises a one-cycle update pulse, together with the index of the register that was written. An active-low reset clears everything asynchronously.

Top module: `serdac_ctrl_port`

## Requirements
- R1: While `rst_n` is low, `gain_val`, `aux_val` and `upd_pulse` are 0, and they fall to 0 without waiting for a clock edge.
- R2: A frame is the last 12 bits shifted, oldest first: a marker bit whose value has no effect, then the address bit, then 10 data bits with the most significant bit first.
- R3: Address bit 0 writes the data into `gain_val`. Address bit 1 writes it into `aux_val`.
- R4: Each rising edge of `wstrb` commits exactly once: one update pulse follows, and holding `wstrb` high or letting it fall commits nothing more.
- R5: When more than 12 bits are shifted before a strobe, only the most recent 12 take effect.
- R6: The register that the frame does not address keeps its value across a commit.
- R7: Each commit gives `upd_pulse` high for exactly one system clock, with `upd_idx` equal to the address written (0 for gain, 1 for aux). The outputs change in that same cycle.
- R8: Reset also clears the shift register. A strobe after reset with no bits shifted therefore writes 0 to the gain register, with `upd_idx` = 0.
- R9: Shifting bits without a strobe changes neither output register and gives no update pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdata | input | 1 | Serial data line |
| sclk | input | 1 | Shift clock, idles low, shifts on its rising edge |
| wstrb | input | 1 | Write strobe, commits the frame on its rising edge |
| gain_val | output | 10 | Holding register for the gain-control converter |
| aux_val | output | 10 | Holding register for the general-purpose converter |
| upd_pulse | output | 1 | One-cycle pulse on each register commit |
| upd_idx | output | 1 | Index of the register committed with the pulse |

## Verification
The hardest state to reach from the ports is a shift register that reset has cleared while it held a complete, valid frame. The outputs are cleared at the same moment, so they cannot show whether the shift register was cleared too. The stimulus first shifts a full frame addressed to the general-purpose register. It then pulses reset in the middle of a clock period and strobes without shifting. A cleared shift register shows up as a commit to index 0, while the general-purpose register stays at zero. Overlong frames are driven by prefixing five junk ones, and a strobe held high for many cycles checks that no second commit follows.

// File: rtl/sdcp_pkg.sv
package sdcp_pkg;
    localparam int DATA_W  = 10;
    localparam int ADDR_W  = 1;
    localparam int MARK_W  = 1;
    localparam int FRAME_W = MARK_W + ADDR_W + DATA_W;
    localparam int NUM_REGS = 1 << ADDR_W;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic [MARK_W-1:0] mark;
        addr_t             addr;
        data_t             data;
    } frame_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_GAIN = ADDR_W'(0),
        SEL_AUX  = ADDR_W'(1)
    } sel_e;

    function automatic frame_t push_bit(frame_t cur, logic b);
        logic [FRAME_W-1:0] flat;
        flat = cur;
        return frame_t'({flat[FRAME_W-2:0], b});
    endfunction
endpackage

// File: rtl/sdcp_edge_sync.sv
module sdcp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], din};
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/sdcp_shifter.sv
module sdcp_shifter
    import sdcp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   shift_en,
    input  logic   bit_in,
    output frame_t frame_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        frame_o <= '0;
        else if (shift_en) frame_o <= push_bit(frame_o, bit_in);
    end
endmodule

// File: rtl/sdcp_reg_bank.sv
module sdcp_reg_bank
    import sdcp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  frame_t                     frame_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o,
    output logic                       pulse_o,
    output addr_t                      idx_o
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_o[i] <= '0;
            else if (wr_en && (frame_i.addr == ADDR_W'(i)))
                regs_o[i] <= frame_i.data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_o <= 1'b0;
            idx_o   <= '0;
        end else begin
            pulse_o <= wr_en;
            if (wr_en) idx_o <= frame_i.addr;
        end
    end
endmodule

// File: rtl/serdac_ctrl_port.sv
module serdac_ctrl_port
    import sdcp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic              sclk,
    input  logic              wstrb,
    output logic [DATA_W-1:0] gain_val,
    output logic [DATA_W-1:0] aux_val,
    output logic              upd_pulse,
    output logic [ADDR_W-1:0] upd_idx
);
    logic   sd_lvl, sd_rise_unused;
    logic   sc_lvl_unused, sc_rise;
    logic   wr_lvl_unused, wr_rise;
    frame_t frame;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    sdcp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_sd (
        .clk(clk), .rst_n(rst_n), .din(sdata),
        .level(sd_lvl), .rise(sd_rise_unused));

    sdcp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_sc (
        .clk(clk), .rst_n(rst_n), .din(sclk),
        .level(sc_lvl_unused), .rise(sc_rise));

    sdcp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_wr (
        .clk(clk), .rst_n(rst_n), .din(wstrb),
        .level(wr_lvl_unused), .rise(wr_rise));

    sdcp_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(sc_rise),
        .bit_in(sd_lvl), .frame_o(frame));

    sdcp_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_rise), .frame_i(frame),
        .regs_o(regs), .pulse_o(upd_pulse), .idx_o(upd_idx));

    assign gain_val = regs[SEL_GAIN];
    assign aux_val  = regs[SEL_AUX];
endmodule

// File: rtl/sdcp_checker.sv
module sdcp_checker
    import sdcp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_rise,
    input logic              upd_pulse,
    input logic [ADDR_W-1:0] upd_idx,
    input logic [DATA_W-1:0] gain_val,
    input logic [DATA_W-1:0] aux_val
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |=> !upd_pulse); // R7

    AST_STROBE_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rise |=> upd_pulse); // R4

    AST_GAIN_WRITE_KEEPS_AUX: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && upd_idx == ADDR_W'(0)) |-> $stable(aux_val)); // R6

    AST_AUX_WRITE_KEEPS_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && upd_idx == ADDR_W'(1)) |-> $stable(gain_val)); // R6

    AST_NO_COMMIT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_pulse |-> ($stable(gain_val) && $stable(aux_val))); // R9

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEARS: assert (gain_val == '0 && aux_val == '0 && !upd_pulse); // R1
        end
    end
endmodule

bind serdac_ctrl_port sdcp_checker u_chk (.*);

// File: tb/serdac_ctrl_port_tb.sv
module serdac_ctrl_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sdata = 1'b0;
    logic sclk = 1'b0;
    logic wstrb = 1'b0;
    logic [9:0] gain_val, aux_val;
    logic upd_pulse;
    logic [0:0] upd_idx;

    int checks = 0;
    int fails = 0;
    int pcount = 0;
    logic [0:0] last_idx = 1'b0;

    always #10 clk = ~clk;

    serdac_ctrl_port u_dut (
        .clk(clk), .rst_n(rst_n), .sdata(sdata), .sclk(sclk), .wstrb(wstrb),
        .gain_val(gain_val), .aux_val(aux_val),
        .upd_pulse(upd_pulse), .upd_idx(upd_idx));

    always @(posedge clk) begin
        if (upd_pulse) begin
            pcount = pcount + 1;
            last_idx = upd_idx;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        sdata = b;
        wait_clk(4);
        sclk = 1'b1;
        wait_clk(4);
        sclk = 1'b0;
        wait_clk(2);
    endtask

    task automatic shift_frame(input logic mark, input logic addr, input logic [9:0] d);
        shift_bit(mark);
        shift_bit(addr);
        for (int i = 9; i >= 0; i--) shift_bit(d[i]);
    endtask

    task automatic strobe(input int hold);
        wait_clk(2);
        pcount = 0;
        wstrb = 1'b1;
        wait_clk(hold);
        wstrb = 1'b0;
        wait_clk(6);
    endtask

    task automatic t_reset;
        check("R1 gain after reset", gain_val, 0);
        check("R1 aux after reset", aux_val, 0);
        check("R1 pulse after reset", upd_pulse, 0);
    endtask

    task automatic t_gain_write;
        shift_frame(1'b1, 1'b0, 10'h2A5);
        strobe(6);
        check("R3 gain written", gain_val, 'h2A5);
        check("R6 aux untouched", aux_val, 0);
        check("R7 one pulse", pcount, 1);
        check("R7 idx gain", last_idx, 0);
    endtask

    task automatic t_aux_write;
        shift_frame(1'b0, 1'b1, 10'h15A);
        strobe(6);
        check("R2 aux written marker 0", aux_val, 'h15A);
        check("R6 gain kept", gain_val, 'h2A5);
        check("R7 idx aux", last_idx, 1);
    endtask

    task automatic t_overlong;
        for (int i = 0; i < 5; i++) shift_bit(1'b1);
        shift_frame(1'b1, 1'b0, 10'h001);
        strobe(6);
        check("R5 gain last 12 bits", gain_val, 'h001);
        check("R5 aux kept", aux_val, 'h15A);
    endtask

    task automatic t_no_strobe;
        pcount = 0;
        shift_frame(1'b0, 1'b1, 10'h3FF);
        wait_clk(6);
        check("R9 gain no strobe", gain_val, 'h001);
        check("R9 aux no strobe", aux_val, 'h15A);
        check("R9 no pulse", pcount, 0);
        strobe(30);
        check("R4 long strobe one pulse", pcount, 1);
        check("R2 aux 3FF", aux_val, 'h3FF);
    endtask

    task automatic t_reset_mid;
        shift_frame(1'b1, 1'b1, 10'h3C3);
        @(posedge clk);
        #5;
        rst_n = 1'b0;
        #1;
        check("R1 async gain clear", gain_val, 0);
        check("R1 async aux clear", aux_val, 0);
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        strobe(6);
        check("R8 commit after reset pulse", pcount, 1);
        check("R8 idx zero", last_idx, 0);
        check("R8 aux stays zero", aux_val, 0);
        check("R8 gain zero", gain_val, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_clk(5);
        t_reset;
        rst_n = 1'b1;
        wait_clk(4);
        t_gain_write;
        t_aux_write;
        t_overlong;
        t_no_strobe;
        t_reset_mid;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule